// File: doc/BRIEF.md
# Multi-Entry Sequential Key Lock

This block guards a small piece of stateful logic with a lock state machine that reads its key from the same data input the guarded logic consumes. After reset the lock sits in the first cycle of entry sequence 0. Only when eight correct key bytes arrive on consecutive cycles does it move to its one open state. While locked, a nonzero corruption vector is XORed onto the guarded logic's output nets, and its value changes with every lock state.

While the lock is open, an external timer may raise a relock request with an entry index. The lock then captures the guarded register into a shadow register and drops into the first cycle of the chosen entry sequence. Each entry has its own eight-byte key. During the lock the guarded register holds its value. When the sequence completes, the register is reloaded from the shadow. The `auth_o` flag tells the timer when the lock is open.

Top module: `seq_lock_top`

## Requirements
- R1: After reset is released, `auth_o` is 0, the lock is at entry 0 step 0 (`corrupt_o` = 1), and the guarded accumulator is 0, so `data_o` = 8'h11.
- R2: The key is read from `data_i`. The key byte expected at entry e, step s is (165 + 59·e + 23·s) mod 256. A sequence that is correct for one entry does not open the lock while it waits in another entry.
- R3: When the correct bytes for steps 0 to 7 of the current entry are applied on eight consecutive cycles, `auth_o` is 1 in the cycle after the eighth byte.
- R4: A wrong byte at any step returns the lock to step 0 of the same entry, so the full eight-byte sequence has to be applied again.
- R5: While open, `corrupt_o` is 0 and `data_o` equals the accumulator.
- R6: While locked at entry e, step s, `corrupt_o` = ((5·e + 3·s) mod 15) + 1. This value is never zero and it differs between adjacent steps.
- R7: A relock request while open puts the lock into entry `bj_idx_i`, step 0, in the next cycle. A relock request while locked has no effect.
- R8: While open and with no relock request, the accumulator adds `data_i` modulo 256 on every clock. On the relock cycle and while locked, it holds its value.
- R9: On relock, the accumulator value is saved. On the clock that completes a sequence, the accumulator is reloaded from the saved value.
- R10: `data_o` bit i equals accumulator bit i XOR `corrupt_o` bit (i mod 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 8 | Shared primary input: guarded data and key bytes |
| bj_req_i | input | 1 | Relock request from the timer |
| bj_idx_i | input | 2 | Entry sequence selected by the relock |
| data_o | output | 8 | Guarded output after corruption |
| corrupt_o | output | 4 | Corruption vector |
| auth_o | output | 1 | High only while the lock is open |

## Verification
All outputs are decoded from registers. A byte or request applied before a rising edge therefore shows its effect in the cycle right after that edge: the open flag after the eighth key byte, the new entry's corruption value after a relock, and the restored accumulator on `data_o` in the first open cycle. The bench drives its inputs on the falling edge and advances a behavioural model on the rising edge. It then compares all three outputs at the next falling edge, so every result is sampled exactly one edge after its cause. Directed checks at those same points cover the wrong-byte retry, the cross-entry key, the ignored request while locked, and the restore value.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic {
    LK_LOCKED = 1'b0,
    LK_OPEN   = 1'b1
  } lock_mode_e;
endpackage

// File: rtl/lock_key_gen.sv
module lock_key_gen #(
  parameter int DW      = 8,
  parameter int EW      = 2,
  parameter int SW      = 3
) (
  input  logic [EW-1:0] entry_i,
  input  logic [SW-1:0] step_i,
  output logic [DW-1:0] key_o
);
  // key spread per entry and per step; truncated to the input width
  always_comb begin
    key_o = DW'(32'd165 + 32'd59 * 32'(entry_i) + 32'd23 * 32'(step_i));
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CW      = 4,
  parameter int N_ENT   = 4,
  parameter int SEQ_LEN = 8,
  localparam int EW     = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int SW     = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1,
  localparam int CMOD   = (1 << CW) - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] key_i,
  input  logic          bj_req_i,
  input  logic [EW-1:0] bj_idx_i,
  output logic          open_o,
  output logic          save_o,
  output logic          restore_o,
  output logic [CW-1:0] corr_o
);
  localparam logic [SW-1:0] LAST = SW'(SEQ_LEN - 1);

  lock_mode_e    mode_q;
  logic [EW-1:0] entry_q;
  logic [SW-1:0] step_q;
  logic [DW-1:0] exp_key;
  logic          hit;

  lock_key_gen #(.DW(DW), .EW(EW), .SW(SW)) u_key (
    .entry_i(entry_q),
    .step_i (step_q),
    .key_o  (exp_key)
  );

  assign hit       = (key_i == exp_key);
  assign open_o    = (mode_q == LK_OPEN);
  assign save_o    = open_o && bj_req_i;
  assign restore_o = !open_o && hit && (step_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= LK_LOCKED;
      entry_q <= '0;
      step_q  <= '0;
    end else if (mode_q == LK_OPEN) begin
      if (bj_req_i) begin
        mode_q  <= LK_LOCKED;
        entry_q <= bj_idx_i;
        step_q  <= '0;
      end
    end else if (!hit) begin
      step_q <= '0;
    end else if (step_q == LAST) begin
      mode_q <= LK_OPEN;
      step_q <= '0;
    end else begin
      step_q <= step_q + 1'b1;
    end
  end

  // locked states always carry a nonzero, state-dependent mask
  always_comb begin
    if (open_o) corr_o = '0;
    else corr_o = CW'(((5 * int'(entry_q) + 3 * int'(step_q)) % CMOD) + 1);
  end

  // R7
  relock_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && bj_req_i) |=> (!open_o && entry_q == $past(bj_idx_i) && step_q == '0));
  // R7
  locked_req_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o && !hit) |=> (!open_o && $stable(entry_q)));
  // R4
  wrong_key_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o && !hit) |=> (step_q == '0));
  // R6
  locked_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_o |-> (corr_o != '0));
  // R5
  open_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |-> (corr_o == '0));
endmodule

// File: rtl/guarded_acc.sv
module guarded_acc #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          run_i,
  input  logic          save_i,
  input  logic          restore_i,
  input  logic [CW-1:0] corr_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] acc_q, shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (save_i) shadow_q <= acc_q;
      if (restore_i) acc_q <= shadow_q;
      else if (run_i) acc_q <= acc_q + data_i;
    end
  end

  // corruption bits wrap across the output nets
  for (genvar i = 0; i < DW; i++) begin : g_xor
    assign data_o[i] = acc_q[i] ^ corr_i[i % CW];
  end

  // R8
  frozen_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restore_i) |=> $stable(acc_q));
  // R9
  restore_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (acc_q == $past(shadow_q)));
endmodule

// File: rtl/seq_lock_top.sv
module seq_lock_top #(
  parameter int DW      = 8,
  parameter int CW      = 4,
  parameter int N_ENT   = 4,
  parameter int SEQ_LEN = 8,
  localparam int EW     = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          bj_req_i,
  input  logic [EW-1:0] bj_idx_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] corrupt_o,
  output logic          auth_o
);
  logic open, save, restore;

  lock_fsm #(.DW(DW), .CW(CW), .N_ENT(N_ENT), .SEQ_LEN(SEQ_LEN)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_i    (data_i),
    .bj_req_i (bj_req_i),
    .bj_idx_i (bj_idx_i),
    .open_o   (open),
    .save_o   (save),
    .restore_o(restore),
    .corr_o   (corrupt_o)
  );

  guarded_acc #(.DW(DW), .CW(CW)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .run_i    (open && !bj_req_i),
    .save_i   (save),
    .restore_i(restore),
    .corr_i   (corrupt_o),
    .data_o   (data_o)
  );

  assign auth_o = open;
endmodule

// File: tb/seq_lock_top_test.sv
`timescale 1ns/1ps
module seq_lock_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] din = '0;
  logic       bj = 1'b0;
  logic [1:0] bidx = '0;
  logic [7:0] dout;
  logic [3:0] corr;
  logic       auth;

  int checks = 0, fails = 0;
  int m_open, m_e, m_s, m_acc, m_sh;
  bit done = 0;

  always #4 clk = ~clk;

  seq_lock_top uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din), .bj_req_i(bj),
    .bj_idx_i(bidx), .data_o(dout), .corrupt_o(corr), .auth_o(auth)
  );

  function automatic int key_of(int e, int s);
    return (165 + 59 * e + 23 * s) % 256;
  endfunction

  function automatic int corr_of();
    if (m_open != 0) return 0;
    return ((5 * m_e + 3 * m_s) % 15) + 1;
  endfunction

  function automatic int dout_of();
    int c = corr_of();
    int r = 0;
    for (int i = 0; i < 8; i++)
      r |= (((m_acc >> i) & 1) ^ ((c >> (i % 4)) & 1)) << i;
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3/R5 auth_o", int'(auth), m_open);
    chk("R6 corrupt_o", int'(corr), corr_of());
    chk("R10 data_o", int'(dout), dout_of());
  endtask

  task automatic model_step(int d, int b, int idx);
    if (m_open != 0) begin
      if (b != 0) begin
        m_sh = m_acc; m_open = 0; m_e = idx; m_s = 0;
      end else m_acc = (m_acc + d) % 256;
    end else if (d == key_of(m_e, m_s)) begin
      if (m_s == 7) begin m_open = 1; m_s = 0; m_acc = m_sh; end
      else m_s++;
    end else m_s = 0;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(int d, int b = 0, int idx = 0);
    din = 8'(d); bj = (b != 0); bidx = 2'(idx);
    @(posedge clk);
    model_step(d, b, idx);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; din = '0; bj = 1'b0; bidx = '0;
    m_open = 0; m_e = 0; m_s = 0; m_acc = 0; m_sh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic apply_seq(int e);
    for (int s = 0; s < 8; s++) cyc(key_of(e, s));
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 auth_o", int'(auth), 0);
    chk("R1 corrupt_o", int'(corr), 1);
    chk("R1 data_o", int'(dout), 8'h11);
    compare_all();

    // R2 / R3 startup sequence for entry 0
    apply_seq(0);
    chk("R3 open after entry-0 sequence", int'(auth), 1);
    chk("R5 zero mask", int'(corr), 0);

    // R8 accumulate with wrap
    cyc(10); cyc(20); cyc(3); cyc(255);
    chk("R8 accumulated", int'(dout), 32);

    // R7 relock to entry 2; data on that cycle is ignored (R8)
    cyc(7, 1, 2);
    chk("R7 locked after request", int'(auth), 0);
    chk("R6 entry-2 mask", int'(corr), 11);
    chk("R10 locked data_o", int'(dout), 32 ^ 8'hBB);

    // R7 request while locked has no effect on the entry
    cyc(0, 1, 1);
    chk("R7 entry kept", int'(corr), 11);

    // R4 wrong byte at step 5, then remaining correct bytes do not open
    for (int s = 0; s < 5; s++) cyc(key_of(2, s));
    cyc(key_of(2, 5) ^ 1);
    chk("R4 back to step 0", int'(corr), 11);
    for (int s = 5; s < 8; s++) cyc(key_of(2, s));
    chk("R4 still locked", int'(auth), 0);

    // R9 full sequence restores saved value
    apply_seq(2);
    chk("R3 reopened", int'(auth), 1);
    chk("R9 restored value", int'(dout), 32);

    // R2 key of another entry does not open
    cyc(5);
    cyc(9, 1, 3);
    apply_seq(1);
    chk("R2 foreign key rejected", int'(auth), 0);
    apply_seq(3);
    chk("R2 entry-3 key opens", int'(auth), 1);
    chk("R9 restored after entry 3", int'(dout), 37);

    // R7 relock to entry 0 and reopen
    cyc(1, 1, 0);
    chk("R6 entry-0 mask", int'(corr), 1);
    apply_seq(0);
    chk("R9 restored after entry 0", int'(dout), 37);

    // R1 mid-run reset
    cyc(50);
    do_reset();
    chk("R1 reset clears", int'(dout), 8'h11);
    chk("R1 reset locks", int'(auth), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule